// File: doc/BRIEF.md
# Ring-Buffer FIFO with One Reserved Slot

This block is a single-clock first-in first-out queue. Words live in a small addressed memory that is treated as a ring. Two pointer registers hold the address of the next slot to fill and the next slot to drain, so a stored word never moves. The producer offers a word with `wrValid` and sees back-pressure on `wrFull`. The consumer asks for a word with `rdReq`, watches `rdEmpty`, and picks up the word on `rdData` one clock later.

There is no occupancy counter and no extra wrap bit. Both flags come from comparing the two pointers alone. Equal pointers mean the queue is empty. A write pointer one step behind the read pointer means it is full. One slot of the ring is therefore never filled, and the usable capacity is one word less than the memory depth. Each pointer moves only after its own access, so the two sides need no shared arbitration.

Top module: `ringFifo`

## Requirements
- R1: A synchronous active-high `rst` sets both pointers to zero. Then `rdEmpty` is 1, `wrFull` is 0 and `rdData` is 0. Reset takes priority over any request in the same cycle.
- R2: A write with `wrValid`=1 while `wrFull`=0 stores `wrData` in the slot addressed by the write pointer. The write pointer then advances by one modulo the depth (7 wraps to 0 with ADDR_W=3).
- R3: A read with `rdReq`=1 while `rdEmpty`=0 presents the oldest stored word on `rdData` after the next rising edge. The read pointer then advances by one modulo the depth. Words leave in the order they were accepted, including across pointer wrap.
- R4: A write while `wrFull`=1 is ignored. No slot is written, the write pointer holds, and the ignored word never appears on `rdData`.
- R5: A read while `rdEmpty`=1 is ignored. The read pointer holds, `rdData` keeps its value and `rdEmpty` stays 1.
- R6: `rdEmpty` is 1 exactly when the pointers are equal. `wrFull` is 1 exactly when the write pointer plus one, wrapped, equals the read pointer. The usable capacity is therefore 2^ADDR_W-1 words: 7 with the defaults.
- R7: A read and a write in the same cycle are both accepted when the flags allow, and the occupancy is unchanged. When empty, only the write is taken. When full, only the read is taken.
- R8: `rdData` changes only on a clock edge where a read was accepted, or on reset.
- R9: Both flags are decoded from the registered pointers. They take their new values in the cycle after the edge that moved a pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | Producer offers a word |
| wrData | input | DATA_W | Word to store |
| wrFull | output | 1 | No free slot; writes are ignored |
| rdReq | input | 1 | Consumer requests the oldest word |
| rdData | output | DATA_W | Word from the last accepted read |
| rdEmpty | output | 1 | Nothing stored; reads are ignored |

## Verification
The awkward states are the two flag boundaries with both requests raised in the same cycle. At full, the read must win and the write must be dropped. At empty, the write must win and the read must be dropped. Reaching either one from the ports takes an exact run of accepted writes and reads. The vector table steps through such a run: it fills the ring to seven words, offers a marked word together with a read, and then drains. The marked word must never appear on `rdData`. A long model-checked stream then drives the pointers around the ring many times with mixed request patterns.

// File: rtl/ringFifoPkg.sv
package ringFifoPkg;
  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
  } fifoStrobes_t;
endpackage

// File: rtl/ringFifoCtrl.sv
module ringFifoCtrl
  import ringFifoPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic              rdReq,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic              full,
  output logic              empty
);
  logic [ADDR_W-1:0] wrPtrInc;
  logic [ADDR_W-1:0] rdPtrInc;

  // Plain unsigned overflow provides the ring wrap.
  always_comb begin
    wrPtrInc = wrPtr + 1'b1;
    rdPtrInc = rdPtr + 1'b1;
  end

  // Flags are decoded from registered pointers only.
  always_comb begin
    empty = (wrPtr == rdPtr);
    full  = (wrPtrInc == rdPtr);
  end

  always_comb begin
    strobes.wrAccept = wrValid && !full;
    strobes.rdAccept = rdReq && !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
    end else if (strobes.wrAccept) begin
      wrPtr <= wrPtrInc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
    end else if (strobes.rdAccept) begin
      rdPtr <= rdPtrInc;
    end
  end
endmodule

// File: rtl/ringFifoData.sv
module ringFifoData
  import ringFifoPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic [ADDR_W-1:0] rdPtr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ringMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrAccept) begin
      ringMem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobes.rdAccept) begin
      rdData <= ringMem[rdPtr];
    end
  end
endmodule

// File: rtl/ringFifo.sv
module ringFifo
  import ringFifoPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);
  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  ringFifoCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .wrValid (wrValid),
    .rdReq   (rdReq),
    .strobes (strobes),
    .wrPtr   (wrPtr),
    .rdPtr   (rdPtr),
    .full    (wrFull),
    .empty   (rdEmpty)
  );

  ringFifoData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrPtr   (wrPtr),
    .rdPtr   (rdPtr),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/ringFifoChecker.sv
module ringFifoChecker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wrValid,
  input logic              wrFull,
  input logic              rdReq,
  input logic              rdEmpty,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0] rdPtr
);
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (rdEmpty && !wrFull && rdData == '0));

  a_r2_write_advance: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !wrFull) |=> (wrPtr == ADDR_W'($past(wrPtr) + 1'b1)));

  a_r3_read_advance: assert property (@(posedge clk) disable iff (rst)
    (rdReq && !rdEmpty) |=> (rdPtr == ADDR_W'($past(rdPtr) + 1'b1)));

  a_r4_full_blocks: assert property (@(posedge clk) disable iff (rst)
    wrFull |=> $stable(wrPtr));

  a_r5_empty_blocks: assert property (@(posedge clk) disable iff (rst)
    rdEmpty |=> ($stable(rdPtr) && $stable(rdData)));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wrFull && rdEmpty));

  a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
    !(rdReq && !rdEmpty) |=> $stable(rdData));
endmodule

bind ringFifo ringFifoChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rst     (rst),
  .wrValid (wrValid),
  .wrFull  (wrFull),
  .rdReq   (rdReq),
  .rdEmpty (rdEmpty),
  .rdData  (rdData),
  .wrPtr   (wrPtr),
  .rdPtr   (rdPtr)
);

// File: tb/ringFifo_test.sv
module ringFifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CAP = (1 << ADDR_W) - 1;
  localparam int NVEC = 20;

  // {wrValid, rdReq, wrData, expEmpty, expFull, expRdData}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 8'h00},  // R2 first write
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'hA1},  // R3 read back
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'hA1},  // R5 read on empty
    {1'b1, 1'b1, 8'hB2, 1'b0, 1'b0, 8'hA1},  // R7 both on empty
    {1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 8'hB2},  // R7 both accepted
    {1'b1, 1'b0, 8'h04, 1'b0, 1'b0, 8'hB2},
    {1'b1, 1'b0, 8'h05, 1'b0, 1'b0, 8'hB2},
    {1'b1, 1'b0, 8'h06, 1'b0, 1'b0, 8'hB2},
    {1'b1, 1'b0, 8'h07, 1'b0, 1'b0, 8'hB2},
    {1'b1, 1'b0, 8'h08, 1'b0, 1'b0, 8'hB2},
    {1'b1, 1'b0, 8'h09, 1'b0, 1'b1, 8'hB2},  // R6 seventh word fills
    {1'b1, 1'b0, 8'hEE, 1'b0, 1'b1, 8'hB2},  // R4 write on full
    {1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 8'hC3},  // R7 both on full
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h04},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h05},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h06},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h07},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h08},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h09},  // R9 empty after drain
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h09}   // R8 hold on empty
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              wrValid;
  logic [DATA_W-1:0] wrData;
  logic              wrFull;
  logic              rdReq;
  logic [DATA_W-1:0] rdData;
  logic              rdEmpty;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  ringFifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk     (clk),
    .rst     (rst),
    .wrValid (wrValid),
    .wrData  (wrData),
    .wrFull  (wrFull),
    .rdReq   (rdReq),
    .rdData  (rdData),
    .rdEmpty (rdEmpty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [DATA_W-1:0] model [$];
  logic [DATA_W-1:0] expRd;

  initial begin
    rst = 1'b1; wrValid = 1'b0; rdReq = 1'b0; wrData = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "reset empty", 32'(rdEmpty), 32'd1);
    check("R1", "reset full", 32'(wrFull), 32'd0);
    check("R1", "reset data", 32'(rdData), 32'd0);
    rst = 1'b0;

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      wrValid = VEC[i][19];
      rdReq   = VEC[i][18];
      wrData  = VEC[i][17:10];
      @(negedge clk);
      check("R6", $sformatf("vec%0d empty", i), 32'(rdEmpty), 32'(VEC[i][9]));
      check("R6", $sformatf("vec%0d full", i), 32'(wrFull), 32'(VEC[i][8]));
      check("R3", $sformatf("vec%0d data", i), 32'(rdData), 32'(VEC[i][7:0]));
    end
    wrValid = 1'b0; rdReq = 1'b0;

    // Long stream with a queue model: wraps the pointers many times (R2, R3, R7, R9)
    expRd = rdData;
    for (int i = 0; i < 400; i++) begin
      logic wv, rr, wAcc, rAcc;
      if (i < 150) begin
        wv = (i % 4) != 3; rr = (i % 3) == 0;
      end else if (i < 280) begin
        wv = (i % 5) == 0; rr = (i % 4) != 0;
      end else begin
        wv = (i % 2) == 0; rr = (i % 7) < 4;
      end
      wAcc = wv && (model.size() < CAP);
      rAcc = rr && (model.size() > 0);
      wrValid = wv; rdReq = rr; wrData = DATA_W'(i * 37 + 5);
      if (rAcc) expRd = model.pop_front();
      if (wAcc) model.push_back(wrData);
      @(negedge clk);
      check("R9", "stream empty", 32'(rdEmpty), 32'(model.size() == 0));
      check("R9", "stream full", 32'(wrFull), 32'(model.size() == CAP));
      check("R3", "stream data", 32'(rdData), 32'(expRd));
    end
    wrValid = 1'b0; rdReq = 1'b0;

    // Mid-operation reset with requests present (R1)
    while (model.size() < 3) begin
      wrValid = 1'b1; wrData = 8'h5A; model.push_back(wrData);
      @(negedge clk);
    end
    wrValid = 1'b0; rdReq = 1'b1;
    @(negedge clk);
    check("R8", "read before reset", 32'(rdData), 32'(model[0]));
    rst = 1'b1; wrValid = 1'b1; rdReq = 1'b1;
    @(negedge clk);
    check("R1", "mid reset empty", 32'(rdEmpty), 32'd1);
    check("R1", "mid reset full", 32'(wrFull), 32'd0);
    check("R1", "mid reset data", 32'(rdData), 32'd0);
    rst = 1'b0; wrValid = 1'b0; rdReq = 1'b1;
    @(negedge clk);
    check("R5", "read after reset", 32'(rdData), 32'd0);
    check("R5", "still empty", 32'(rdEmpty), 32'd1);
    rdReq = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule